// File: doc/BRIEF.md
# Dual-port USB PHY power sequencer

This block powers up and powers down a USB 2.0 PHY that serves one or two ports. Both ports share one reference clock and one power-on reset, and each port has its own UTMI reset. Each port raises a one-cycle init or exit pulse. The block steps the shared and per-port controls through fixed wait intervals. While a port is fully up, the block shows that port's `port_up` flag.

Wait intervals are given in microseconds and a clock frequency in kHz. The block converts them to cycle counts when it is elaborated. During a cold bring-up it must write the PHY's clock-enable register. It does this with a request/acknowledge handshake to an external test-bus writer and stalls until that writer acknowledges.

A use count, held as a vector of active ports, decides how much of the sequence runs. The first port to come up runs the full cold sequence. A second port only releases its own reset and waits. The shared controls go off only when the last active port leaves.

Top module: `usbphy_pwr_seq`

## Requirements
- R1: After reset: `refclk_en`=0, `por_hold`=1, every `utmi_hold` bit =1, `port_up`=0, `wr_req`=0 and `busy`=0.
- R2: On a cold init (no port active), `refclk_en` rises first. `por_hold` falls exactly T_REF cycles later. A wait of N microseconds lasts ceil(N*CLK_KHZ/1000) cycles, with a minimum of 1.
- R3: `wr_req` rises exactly T_POR cycles after `por_hold` falls. While it is high it carries port 0, register address 0x06 and data 0x04, whichever port requested init. There is exactly one write per cold init.
- R4: `wr_req` stays high until it is sampled together with `wr_ack` on a clock edge, and falls on that edge. An acknowledge given d cycles late keeps `wr_req` high for d+1 cycles.
- R5: The requesting port's `utmi_hold` falls exactly T_WCK cycles after `wr_req` falls. Its `port_up` bit rises exactly T_PRT cycles after that.
- R6: An init of a port while the other port is active issues no register write and leaves `refclk_en` and `por_hold` unchanged. It releases that port's `utmi_hold`, and `port_up` follows T_PRT cycles later.
- R7: An exit while another port remains active sets that port's `utmi_hold` and clears its `port_up` bit. `refclk_en` and `por_hold` are left unchanged.
- R8: An exit of the last active port sets its `utmi_hold` on one edge, sets `por_hold` on the next edge, and clears `refclk_en` on the edge after that.
- R9: Requests that arrive while `busy` is high are held and serviced after the running sequence completes.
- R10: An exit of an inactive port and an init of an already active port change no output other than a momentary `busy`.
- R11: When several requests are pending, exits are served before inits, and a lower port index before a higher one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, frequency CLK_KHZ |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req | input | NPORT | One-cycle init pulse per port |
| exit_req | input | NPORT | One-cycle exit pulse per port |
| wr_ack | input | 1 | Test-bus writer accepted the register write |
| port_up | output | NPORT | Port fully brought up |
| busy | output | 1 | A sequence is in progress |
| refclk_en | output | 1 | Shared reference clock enable |
| por_hold | output | 1 | Shared power-on reset, 1 = held in reset |
| utmi_hold | output | NPORT | Per-port UTMI reset, 1 = held in reset |
| wr_req | output | 1 | Register write request to the test-bus writer |
| wr_port | output | 3 | Target port of the write |
| wr_addr | output | 8 | Target register address |
| wr_data | output | 8 | Write data |

## Verification
The assertions assume that `wr_ack` is high only while `wr_req` is high, and only for the edge that ends the handshake. The bench's acknowledge driver therefore raises `wr_ack` only after it sees `wr_req`, and drops it as soon as `wr_req` falls. The assertions also take every init and exit request to be a single-cycle pulse. The bench produces requests only through a pulse task. Every acknowledge latency from 0 to 3 cycles is swept, alternating which port comes up cold and which port leaves first.

// File: rtl/usbphy_seq_pkg.sv
package usbphy_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLK_WAIT,
    ST_POR_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_UTMI_WAIT,
    ST_OFF_POR,
    ST_OFF_CLK
  } seq_state_e;

  localparam logic [2:0] CKEN_PORT = 3'd0;
  localparam logic [7:0] CKEN_ADDR = 8'h06;
  localparam logic [7:0] CKEN_DATA = 8'h04;

  // microseconds to clock cycles, rounded up, never zero
  function automatic int unsigned wait_cycles(int unsigned us, int unsigned khz);
    int unsigned c;
    c = (us * khz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/usbphy_seq_timer.sv
module usbphy_seq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] len,
  output logic          expired
);
  logic [TW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= len - TW'(1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - TW'(1);
    end
  end

  assign expired = run && (cnt == '0);
endmodule

// File: rtl/usbphy_seq_reqs.sv
module usbphy_seq_reqs #(
  parameter int NPORT = 2,
  parameter int IW    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] init_req,
  input  logic [NPORT-1:0] exit_req,
  input  logic [NPORT-1:0] take_init,
  input  logic [NPORT-1:0] take_exit,
  output logic             pick_valid,
  output logic             pick_exit,
  output logic [IW-1:0]    pick_idx
);
  logic [NPORT-1:0] pend_init, pend_exit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_init <= '0;
      pend_exit <= '0;
    end else begin
      pend_init <= (pend_init & ~take_init) | init_req;
      pend_exit <= (pend_exit & ~take_exit) | exit_req;
    end
  end

  // exits first, then lowest index
  always_comb begin
    pick_exit  = |pend_exit;
    pick_valid = pick_exit || (|pend_init);
    pick_idx   = '0;
    for (int i = NPORT - 1; i >= 0; i--) begin
      if (pick_exit ? pend_exit[i] : pend_init[i]) pick_idx = IW'(i);
    end
  end
endmodule

// File: rtl/usbphy_seq_fsm.sv
module usbphy_seq_fsm
  import usbphy_seq_pkg::*;
#(
  parameter int          NPORT = 2,
  parameter int          IW    = 1,
  parameter int          TW    = 8,
  parameter int unsigned T_REF = 1,
  parameter int unsigned T_POR = 1,
  parameter int unsigned T_WCK = 1,
  parameter int unsigned T_PRT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pick_valid,
  input  logic             pick_exit,
  input  logic [IW-1:0]    pick_idx,
  input  logic             tmr_done,
  input  logic             wr_ack,
  output logic [NPORT-1:0] take_init,
  output logic [NPORT-1:0] take_exit,
  output logic             tmr_start,
  output logic [TW-1:0]    tmr_len,
  output logic             refclk_en,
  output logic             por_hold,
  output logic [NPORT-1:0] utmi_hold,
  output logic [NPORT-1:0] active,
  output logic             wr_req,
  output logic             busy
);
  seq_state_e       st, nxt;
  logic [IW-1:0]    cur;
  logic [NPORT-1:0] sel;
  logic             rel_now;
  logic [IW-1:0]    rel_idx;

  assign sel = NPORT'(1) << pick_idx;

  always_comb begin
    nxt       = st;
    tmr_start = 1'b0;
    tmr_len   = '0;
    take_init = '0;
    take_exit = '0;
    unique case (st)
      ST_IDLE: if (pick_valid) begin
        if (pick_exit) begin
          take_exit = sel;
          if (((active & sel) != '0) && ((active & ~sel) == '0)) nxt = ST_OFF_POR;
        end else begin
          take_init = sel;
          if ((active & sel) == '0) begin
            tmr_start = 1'b1;
            if (active == '0) begin nxt = ST_CLK_WAIT;  tmr_len = TW'(T_REF); end
            else              begin nxt = ST_UTMI_WAIT; tmr_len = TW'(T_PRT); end
          end
        end
      end
      ST_CLK_WAIT: if (tmr_done) begin
        nxt = ST_POR_WAIT; tmr_start = 1'b1; tmr_len = TW'(T_POR);
      end
      ST_POR_WAIT: if (tmr_done) nxt = ST_WR_REQ;
      ST_WR_REQ: if (wr_ack) begin
        nxt = ST_WR_WAIT; tmr_start = 1'b1; tmr_len = TW'(T_WCK);
      end
      ST_WR_WAIT: if (tmr_done) begin
        nxt = ST_UTMI_WAIT; tmr_start = 1'b1; tmr_len = TW'(T_PRT);
      end
      ST_UTMI_WAIT: if (tmr_done) nxt = ST_IDLE;
      ST_OFF_POR:   nxt = ST_OFF_CLK;
      default:      nxt = ST_IDLE;
    endcase
  end

  assign rel_now = (nxt == ST_UTMI_WAIT) && (st != ST_UTMI_WAIT);
  assign rel_idx = (st == ST_IDLE) ? pick_idx : cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur       <= '0;
      refclk_en <= 1'b0;
      por_hold  <= 1'b1;
      utmi_hold <= '1;
      active    <= '0;
    end else begin
      st <= nxt;
      if (st == ST_IDLE && pick_valid && !pick_exit) cur <= pick_idx;
      if (st == ST_IDLE && nxt == ST_CLK_WAIT) refclk_en <= 1'b1;
      if (st == ST_OFF_CLK) refclk_en <= 1'b0;
      if (st == ST_CLK_WAIT && nxt == ST_POR_WAIT) por_hold <= 1'b0;
      if (st == ST_OFF_POR) por_hold <= 1'b1;
      if (rel_now) utmi_hold[rel_idx] <= 1'b0;
      if (take_exit != '0) begin
        utmi_hold <= utmi_hold | (take_exit & active);
        active    <= active & ~take_exit;
      end
      if (st == ST_UTMI_WAIT && tmr_done) active[cur] <= 1'b1;
    end
  end

  assign wr_req = (st == ST_WR_REQ);
  assign busy   = (st != ST_IDLE);
endmodule

// File: rtl/usbphy_pwr_seq.sv
module usbphy_pwr_seq
  import usbphy_seq_pkg::*;
#(
  parameter int unsigned NPORT   = 2,
  parameter int unsigned CLK_KHZ = 50000,
  parameter int unsigned REF_US  = 100,
  parameter int unsigned POR_US  = 300,
  parameter int unsigned WCK_US  = 2000,
  parameter int unsigned PRT_US  = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] init_req,
  input  logic [NPORT-1:0] exit_req,
  input  logic             wr_ack,
  output logic [NPORT-1:0] port_up,
  output logic             busy,
  output logic             refclk_en,
  output logic             por_hold,
  output logic [NPORT-1:0] utmi_hold,
  output logic             wr_req,
  output logic [2:0]       wr_port,
  output logic [7:0]       wr_addr,
  output logic [7:0]       wr_data
);
  localparam int unsigned T_REF = wait_cycles(REF_US, CLK_KHZ);
  localparam int unsigned T_POR = wait_cycles(POR_US, CLK_KHZ);
  localparam int unsigned T_WCK = wait_cycles(WCK_US, CLK_KHZ);
  localparam int unsigned T_PRT = wait_cycles(PRT_US, CLK_KHZ);
  localparam int          TW    = $clog2(max4(T_REF, T_POR, T_WCK, T_PRT) + 1);
  localparam int          IW    = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic [NPORT-1:0] take_init, take_exit;
  logic             pick_valid, pick_exit, tmr_start, tmr_done;
  logic [IW-1:0]    pick_idx;
  logic [TW-1:0]    tmr_len;

  usbphy_seq_reqs #(.NPORT(NPORT), .IW(IW)) u_reqs (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .exit_req(exit_req),
    .take_init(take_init), .take_exit(take_exit),
    .pick_valid(pick_valid), .pick_exit(pick_exit), .pick_idx(pick_idx)
  );

  usbphy_seq_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .len(tmr_len), .expired(tmr_done)
  );

  usbphy_seq_fsm #(
    .NPORT(NPORT), .IW(IW), .TW(TW),
    .T_REF(T_REF), .T_POR(T_POR), .T_WCK(T_WCK), .T_PRT(T_PRT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .pick_valid(pick_valid), .pick_exit(pick_exit), .pick_idx(pick_idx),
    .tmr_done(tmr_done), .wr_ack(wr_ack),
    .take_init(take_init), .take_exit(take_exit),
    .tmr_start(tmr_start), .tmr_len(tmr_len),
    .refclk_en(refclk_en), .por_hold(por_hold), .utmi_hold(utmi_hold),
    .active(port_up), .wr_req(wr_req), .busy(busy)
  );

  assign wr_port = CKEN_PORT;
  assign wr_addr = CKEN_ADDR;
  assign wr_data = CKEN_DATA;
endmodule

// File: rtl/usbphy_pwr_seq_chk.sv
module usbphy_pwr_seq_chk #(
  parameter int unsigned NPORT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             refclk_en,
  input logic             por_hold,
  input logic [NPORT-1:0] utmi_hold,
  input logic [NPORT-1:0] port_up,
  input logic             wr_req,
  input logic             wr_ack
);
  AST_POR_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    !por_hold |-> refclk_en); // R2

  AST_WR_COLD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (port_up == '0)); // R3

  AST_WR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> wr_req); // R4

  AST_UTMI_NEEDS_POR: assert property (@(posedge clk) disable iff (!rst_n)
    (~utmi_hold != '0) |-> !por_hold); // R5

  AST_UP_IS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (port_up & utmi_hold) == '0); // R5

  AST_SHARED_ON_WHILE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (port_up != '0) |-> (refclk_en && !por_hold)); // R7

  AST_POR_AFTER_UTMI: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_hold) |-> ($past(&utmi_hold) && !$past(por_hold))); // R8

  AST_CLK_OFF_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(refclk_en) |-> ($past(por_hold) && (&utmi_hold))); // R8
endmodule

bind usbphy_pwr_seq usbphy_pwr_seq_chk #(.NPORT(NPORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .refclk_en(refclk_en), .por_hold(por_hold),
  .utmi_hold(utmi_hold), .port_up(port_up), .wr_req(wr_req), .wr_ack(wr_ack)
);

// File: tb/sim_usbphy_pwr_seq.sv
`timescale 1ns/1ps
module sim_usbphy_pwr_seq;
  localparam int KHZ = 50;
  localparam int T_REF = (100 * KHZ + 999) / 1000;
  localparam int T_POR = (300 * KHZ + 999) / 1000;
  localparam int T_WCK = (2000 * KHZ + 999) / 1000;
  localparam int T_PRT = (2000 * KHZ + 999) / 1000;

  logic       clk = 1'b0, rst_n = 1'b0, wr_ack = 1'b0;
  logic [1:0] init_req = '0, exit_req = '0;
  logic [1:0] port_up, utmi_hold;
  logic       busy, refclk_en, por_hold, wr_req;
  logic [2:0] wr_port;
  logic [7:0] wr_addr, wr_data;

  usbphy_pwr_seq #(.NPORT(2), .CLK_KHZ(KHZ)) u0 (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .exit_req(exit_req),
    .wr_ack(wr_ack), .port_up(port_up), .busy(busy), .refclk_en(refclk_en),
    .por_hold(por_hold), .utmi_hold(utmi_hold), .wr_req(wr_req),
    .wr_port(wr_port), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, ack_dly = 0;
  int t_clk_rise = -1, t_clk_fall = -1, t_por_fall = -1, t_por_rise = -1;
  int t_wr_rise = -1, t_wr_fall = -1, wr_cnt = 0;
  int t_utmi_fall [2], t_utmi_rise [2], t_done_rise [2];
  logic [2:0] cap_port;
  logic [7:0] cap_addr, cap_data;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // event monitor: records the edge number at which each output changed
  initial begin
    logic pc, pp, pw;
    logic [1:0] pu, pd;
    @(posedge rst_n);
    @(negedge clk);
    pc = refclk_en; pp = por_hold; pw = wr_req; pu = utmi_hold; pd = port_up;
    forever begin
      @(negedge clk);
      if (refclk_en && !pc) t_clk_rise = cyc;
      if (!refclk_en && pc) t_clk_fall = cyc;
      if (!por_hold && pp) t_por_fall = cyc;
      if (por_hold && !pp) t_por_rise = cyc;
      if (wr_req && !pw) begin
        t_wr_rise = cyc; wr_cnt++;
        cap_port = wr_port; cap_addr = wr_addr; cap_data = wr_data;
      end
      if (!wr_req && pw) t_wr_fall = cyc;
      for (int i = 0; i < 2; i++) begin
        if (!utmi_hold[i] && pu[i]) t_utmi_fall[i] = cyc;
        if (utmi_hold[i] && !pu[i]) t_utmi_rise[i] = cyc;
        if (port_up[i] && !pd[i]) t_done_rise[i] = cyc;
      end
      pc = refclk_en; pp = por_hold; pw = wr_req; pu = utmi_hold; pd = port_up;
    end
  end

  // test-bus writer model: acknowledges ack_dly cycles after seeing wr_req
  initial begin
    int seen = 0;
    forever begin
      @(negedge clk);
      if (wr_req) begin
        wr_ack = (seen >= ack_dly);
        seen++;
      end else begin
        wr_ack = 1'b0;
        seen = 0;
      end
    end
  end

  task automatic pulse(input logic [1:0] ini, input logic [1:0] ex);
    @(negedge clk);
    init_req = ini; exit_req = ex;
    @(negedge clk);
    init_req = '0; exit_req = '0;
  endtask

  task automatic settle();
    int quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      if (busy) quiet = 0; else quiet++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w0, tcr, tuf;
    for (int i = 0; i < 2; i++) begin
      t_utmi_fall[i] = -1; t_utmi_rise[i] = -1; t_done_rise[i] = -1;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 refclk_en", refclk_en, 0);
    chk("R1 por_hold", por_hold, 1);
    chk("R1 utmi_hold", utmi_hold, 3);
    chk("R1 port_up", port_up, 0);
    chk("R1 wr_req", wr_req, 0);
    chk("R1 busy", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int d = 0; d < 4; d++) begin
      int p = d % 2;
      int q = 1 - p;
      ack_dly = d;
      w0 = wr_cnt;
      pulse(2'(1 << p), 2'b00);
      settle();
      chk("R2 clk->por gap", t_por_fall - t_clk_rise, T_REF);
      chk("R3 por->wr gap", t_wr_rise - t_por_fall, T_POR);
      chk("R3 write count", wr_cnt - w0, 1);
      chk("R3 wr_port", cap_port, 0);
      chk("R3 wr_addr", cap_addr, 8'h06);
      chk("R3 wr_data", cap_data, 8'h04);
      chk("R4 wr_req width", t_wr_fall - t_wr_rise, d + 1);
      chk("R5 wr->utmi gap", t_utmi_fall[p] - t_wr_fall, T_WCK);
      chk("R5 utmi->up gap", t_done_rise[p] - t_utmi_fall[p], T_PRT);
      chk("R5 port_up", port_up, 1 << p);

      tcr = t_clk_rise;
      pulse(2'(1 << q), 2'b00);
      settle();
      chk("R6 no write", wr_cnt - w0, 1);
      chk("R6 clock untouched", t_clk_rise, tcr);
      chk("R6 refclk_en", refclk_en, 1);
      chk("R6 por_hold", por_hold, 0);
      chk("R6 utmi->up gap", t_done_rise[q] - t_utmi_fall[q], T_PRT);
      chk("R6 port_up", port_up, 3);

      begin
        int first = (d < 2) ? q : p;
        int last = 1 - first;
        pulse(2'(1 << first), 2'b00 | 2'b00);
        // the pulse above is an init of an active port: R10
        settle();
        chk("R10 active re-init", port_up, 3);
        chk("R10 no write", wr_cnt - w0, 1);
        pulse(2'b00, 2'(1 << first));
        settle();
        chk("R7 port_up", port_up, 1 << last);
        chk("R7 utmi_hold", utmi_hold, 1 << first);
        chk("R7 refclk_en", refclk_en, 1);
        chk("R7 por_hold", por_hold, 0);
        pulse(2'b00, 2'(1 << last));
        settle();
        chk("R8 utmi->por", t_por_rise - t_utmi_rise[last], 1);
        chk("R8 por->clk", t_clk_fall - t_por_rise, 1);
        chk("R8 utmi_hold", utmi_hold, 3);
        chk("R8 port_up", port_up, 0);
        chk("R8 refclk_en", refclk_en, 0);
      end
    end

    // R10 exit of an inactive port
    tcr = t_clk_rise;
    pulse(2'b00, 2'b10);
    settle();
    chk("R10 inactive exit refclk", refclk_en, 0);
    chk("R10 inactive exit por", por_hold, 1);
    chk("R10 inactive exit utmi", utmi_hold, 3);
    chk("R10 inactive exit clock", t_clk_rise, tcr);

    // R9 init held while busy
    ack_dly = 1;
    w0 = wr_cnt;
    pulse(2'b01, 2'b00);
    repeat (4) @(negedge clk);
    chk("R9 busy during bring-up", busy, 1);
    pulse(2'b10, 2'b00);
    settle();
    chk("R9 both up", port_up, 3);
    chk("R9 single write", wr_cnt - w0, 1);
    chk("R9 port 1 after port 0", (t_utmi_fall[1] > t_done_rise[0]) ? 1 : 0, 1);

    // R11 simultaneous exits: lower index first
    pulse(2'b00, 2'b11);
    settle();
    chk("R11 exit order", t_utmi_rise[1] - t_utmi_rise[0], 1);
    chk("R11 all down", port_up, 0);
    chk("R11 clock off", refclk_en, 0);

    // R11 exit served before init
    pulse(2'b01, 2'b00);
    settle();
    w0 = wr_cnt;
    tuf = t_utmi_fall[0];
    pulse(2'b10, 2'b01);
    settle();
    chk("R11 exit before init", (t_clk_fall < t_clk_rise && t_utmi_rise[0] < t_utmi_fall[1]) ? 1 : 0, 1);
    chk("R11 cold write again", wr_cnt - w0, 1);
    chk("R11 port_up", port_up, 2);
    chk("R11 port 0 stays down", t_utmi_fall[0], tuf);
    pulse(2'b00, 2'b10);
    settle();
    chk("R8 final shutdown", {refclk_en, por_hold, utmi_hold}, 4'b0111);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule